// File: doc/BRIEF.md
# UART Receive Control-Character Filter

This block sits between a UART receiver's deserializer and the receive buffer logic. Every received character is compared against a small table of programmable control-character entries. One shared compare mask decides which bits take part in the comparison, so a single entry can stand for a whole class of characters.

Each table entry carries a valid bit and an action. An end-of-message entry lets the character through to the buffer and flags the end of the message in the same cycle. A reject entry keeps the character out of the buffer, places it in a holding register and sets a sticky interrupt status. A later rejected character overwrites the holding register whether or not software has read it. Characters that match no valid entry go to the buffer-write output one cycle after they arrive. Software programs the table, the mask and the interrupt control through a simple write port.

Top module: `rx_ctlchar_filter`

## Requirements
- R1: After reset, `buf_we`, `buf_eom`, `irq` and `rej_char` are all 0, every entry is invalid and the mask is 0.
- R2: A character with `rx_valid`=1 that matches no valid entry gives `buf_we`=1 with `buf_data` equal to the character on the next cycle, and `buf_eom`=0.
- R3: Entry i matches character c when `((c ^ entry_i) & mask) == 0`. A mask bit of 1 compares that bit and a mask bit of 0 ignores it. The mask is written at address N (8 by default) from `cfg_wdata[15:0]`.
- R4: A character whose deciding entry has action end-of-message (`cfg_wdata[17]`=0) gives `buf_we`=1, `buf_data`=character and `buf_eom`=1 together on the next cycle.
- R5: A character whose deciding entry has action reject (`cfg_wdata[17]`=1) gives `buf_we`=0 on the next cycle. In that same cycle `rej_char` holds the character and the interrupt status is set.
- R6: Each rejected character overwrites `rej_char`, whether or not the previous value was read.
- R7: When several valid entries match, the lowest-numbered one decides the action.
- R8: An entry with valid bit `cfg_wdata[16]`=0 never matches. Entry i is written at address i from `cfg_wdata[15:0]` (character), bit 16 (valid) and bit 17 (action).
- R9: The control register is at address N+1. Bit 0 is the interrupt enable. Writing 1 to bit 1 clears the sticky status. `irq` = status AND enable. When a reject and a clear fall in the same cycle, the reject wins and the status stays set.
- R10: In a cycle after `rx_valid`=0, `buf_we` and `buf_eom` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 16 | Received character |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address: entries 0..N-1, mask N, control N+1 |
| cfg_wdata | input | 18 | Register write data |
| buf_we | output | 1 | Write character to receive buffer |
| buf_data | output | 16 | Character for the buffer |
| buf_eom | output | 1 | End of message, coincident with `buf_we` |
| rej_char | output | 16 | Last rejected character |
| irq | output | 1 | Interrupt: sticky status AND enable |

## Verification
The bench aims at overlapping entries, where a design with the wrong priority would let a higher-numbered reject entry swallow a character that an end-of-message entry should have passed. It sends characters that differ from an entry only in masked-out bits; an inverted or ignored mask would pass them unfiltered. It also lands a reject in the same cycle as a status clear, where a design that favours the clear would lose an interrupt. It checks invalidated entries and back-to-back rejects as well, which catch stale matches and a holding register that fails to update.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  typedef enum logic {
    ACT_EOM    = 1'b0,
    ACT_REJECT = 1'b1
  } ccf_act_e;

  typedef struct packed {
    logic     vld;
    ccf_act_e act;
  } ccf_ctl_t;
endpackage

// File: rtl/ccf_entry_table.sv
module ccf_entry_table
  import ccf_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int CHR_W = 16,
  parameter int AW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [AW-1:0]              cfg_addr,
  input  logic [CHR_W+1:0]           cfg_wdata,
  output logic [N_ENT-1:0][CHR_W-1:0] ent_chr,
  output ccf_ctl_t [N_ENT-1:0]       ent_ctl,
  output logic [CHR_W-1:0]           mask
);
  localparam logic [AW-1:0] MASK_ADDR = AW'(N_ENT);

  // mask register
  logic             mask_en;
  logic [CHR_W-1:0] mask_d;
  always_comb begin
    mask_en = cfg_we && (cfg_addr == MASK_ADDR);
    mask_d  = mask_en ? cfg_wdata[CHR_W-1:0] : mask;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_d;
  end

  // entry registers
  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic             wr_en;
    logic [CHR_W-1:0] chr_d;
    ccf_ctl_t         ctl_d;
    always_comb begin
      wr_en = cfg_we && (cfg_addr == AW'(i));
      chr_d = wr_en ? cfg_wdata[CHR_W-1:0] : ent_chr[i];
      ctl_d = wr_en ? ccf_ctl_t'({cfg_wdata[CHR_W], cfg_wdata[CHR_W+1]}) : ent_ctl[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_chr[i] <= '0;
        ent_ctl[i] <= '{vld: 1'b0, act: ACT_EOM};
      end else begin
        ent_chr[i] <= chr_d;
        ent_ctl[i] <= ctl_d;
      end
    end
  end
endmodule

// File: rtl/ccf_match.sv
module ccf_match
  import ccf_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int CHR_W = 16
) (
  input  logic [CHR_W-1:0]            chr,
  input  logic [N_ENT-1:0][CHR_W-1:0] ent_chr,
  input  ccf_ctl_t [N_ENT-1:0]        ent_ctl,
  input  logic [CHR_W-1:0]            mask,
  output logic [N_ENT-1:0]            win_oh,
  output logic                        hit,
  output ccf_act_e                    hit_act
);
  logic [N_ENT-1:0] raw;

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign raw[i] = ent_ctl[i].vld && (((chr ^ ent_chr[i]) & mask) == '0);
  end

  // lowest index wins
  always_comb begin
    win_oh  = raw & (~raw + N_ENT'(1));
    hit     = |raw;
    hit_act = ACT_EOM;
    for (int i = 0; i < N_ENT; i++) begin
      if (win_oh[i]) hit_act = ent_ctl[i].act;
    end
  end
endmodule

// File: rtl/ccf_irq_ctrl.sv
module ccf_irq_ctrl #(
  parameter int CHR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rej_fire,
  input  logic [CHR_W-1:0] rej_data,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_wdata,
  output logic [CHR_W-1:0] rej_char,
  output logic             irq
);
  logic             en_q, en_d;
  logic             stat_q, stat_d;
  logic [CHR_W-1:0] rej_d;

  always_comb begin
    en_d   = ctl_we ? ctl_wdata[0] : en_q;
    rej_d  = rej_fire ? rej_data : rej_char;
    stat_d = stat_q;
    if (ctl_we && ctl_wdata[1]) stat_d = 1'b0;
    if (rej_fire)               stat_d = 1'b1;  // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      stat_q   <= 1'b0;
      rej_char <= '0;
    end else begin
      en_q     <= en_d;
      stat_q   <= stat_d;
      rej_char <= rej_d;
    end
  end

  assign irq = stat_q & en_q;

  assert_reject_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rej_fire |=> (stat_q && rej_char == $past(rej_data)));

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !(ctl_we && ctl_wdata[1])) |=> stat_q);

  assert_hold_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rej_fire |=> $stable(rej_char));
endmodule

// File: rtl/rx_ctlchar_filter.sv
module rx_ctlchar_filter
  import ccf_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int CHR_W = 16,
  localparam int AW   = $clog2(N_ENT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [CHR_W-1:0] rx_data,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [CHR_W+1:0] cfg_wdata,
  output logic             buf_we,
  output logic [CHR_W-1:0] buf_data,
  output logic             buf_eom,
  output logic [CHR_W-1:0] rej_char,
  output logic             irq
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(N_ENT + 1);

  logic [N_ENT-1:0][CHR_W-1:0] ent_chr;
  ccf_ctl_t [N_ENT-1:0]        ent_ctl;
  logic [CHR_W-1:0]            mask;
  logic [N_ENT-1:0]            win_oh;
  logic                        hit;
  ccf_act_e                    hit_act;

  ccf_entry_table #(.N_ENT(N_ENT), .CHR_W(CHR_W), .AW(AW)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ent_chr(ent_chr), .ent_ctl(ent_ctl), .mask(mask)
  );

  ccf_match #(.N_ENT(N_ENT), .CHR_W(CHR_W)) u_match (
    .chr(rx_data), .ent_chr(ent_chr), .ent_ctl(ent_ctl), .mask(mask),
    .win_oh(win_oh), .hit(hit), .hit_act(hit_act)
  );

  logic rej_fire, ctl_we;
  logic             we_d, eom_d;
  logic [CHR_W-1:0] data_d;

  always_comb begin
    rej_fire = rx_valid && hit && (hit_act == ACT_REJECT);
    ctl_we   = cfg_we && (cfg_addr == CTRL_ADDR);
    we_d     = rx_valid && !rej_fire;
    eom_d    = rx_valid && hit && (hit_act == ACT_EOM);
    data_d   = we_d ? rx_data : buf_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_we   <= 1'b0;
      buf_eom  <= 1'b0;
      buf_data <= '0;
    end else begin
      buf_we   <= we_d;
      buf_eom  <= eom_d;
      buf_data <= data_d;
    end
  end

  ccf_irq_ctrl #(.CHR_W(CHR_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .rej_fire(rej_fire), .rej_data(rx_data),
    .ctl_we(ctl_we), .ctl_wdata(cfg_wdata[1:0]), .rej_char(rej_char), .irq(irq)
  );

  assert_single_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && (hit == (win_oh != '0)));

  assert_eom_with_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_eom |-> buf_we);

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !hit) |=> (buf_we && !buf_eom && buf_data == $past(rx_data)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (!buf_we && !buf_eom));
endmodule

// File: tb/rx_ctlchar_filter_tb_top.sv
module rx_ctlchar_filter_tb_top;
  localparam int N = 8;
  localparam int W = 16;
  localparam int AW = $clog2(N + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [W-1:0] rx_data = '0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [W+1:0] cfg_wdata = '0;
  logic buf_we, buf_eom, irq;
  logic [W-1:0] buf_data, rej_char;

  always #10 clk = ~clk;  // 50 MHz

  rx_ctlchar_filter dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .buf_we(buf_we), .buf_data(buf_data), .buf_eom(buf_eom),
    .rej_char(rej_char), .irq(irq)
  );

  // reference model
  logic [W-1:0] m_chr [N];
  logic         m_vld [N];
  logic         m_act [N];  // 1 = reject
  logic [W-1:0] m_mask, m_rej;
  logic         m_en, m_stat;
  int tests = 0, fails = 0;
  bit done = 0;

  // returns 0 none, 1 eom, 2 reject
  function automatic int classify(input logic [W-1:0] c);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && (((c ^ m_chr[i]) & m_mask) == '0)) return m_act[i] ? 2 : 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int addr, input logic [W+1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < N) begin
      m_chr[addr] = d[W-1:0]; m_vld[addr] = d[W]; m_act[addr] = d[W+1];
    end else if (addr == N) m_mask = d[W-1:0];
    else begin
      m_en = d[0];
      if (d[1]) m_stat = 1'b0;
    end
  endtask

  task automatic set_entry(input int i, input logic [W-1:0] c, input bit v, input bit rej);
    cfg_write(i, {rej, v, c});
  endtask

  task automatic check_out(input string tag, input int cls, input logic [W-1:0] c, input bit sent);
    logic exp_we, exp_eom;
    exp_we  = sent && (cls != 2);
    exp_eom = sent && (cls == 1);
    chk(buf_we == exp_we, tag, "buf_we", W'(buf_we), W'(exp_we));
    chk(buf_eom == exp_eom, tag, "buf_eom", W'(buf_eom), W'(exp_eom));
    if (exp_we) chk(buf_data == c, tag, "buf_data", buf_data, c);
    chk(rej_char == m_rej, tag, "rej_char", rej_char, m_rej);
    chk(irq == (m_stat & m_en), tag, "irq", W'(irq), W'(m_stat & m_en));
  endtask

  task automatic send(input logic [W-1:0] c, input string tag);
    int cls;
    @(negedge clk);
    cls = classify(c);
    rx_valid = 1'b1; rx_data = c;
    @(negedge clk);
    rx_valid = 1'b0;
    if (cls == 2) begin m_rej = c; m_stat = 1'b1; end
    check_out(tag, cls, c, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] c;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin m_chr[i] = '0; m_vld[i] = 0; m_act[i] = 0; end
    m_mask = '0; m_rej = '0; m_en = 0; m_stat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(buf_we == 0 && buf_eom == 0, "R1", "buf_we|eom", W'({buf_we, buf_eom}), '0);
    chk(irq == 0, "R1", "irq", W'(irq), '0);
    chk(rej_char == '0, "R1", "rej_char", rej_char, '0);
    // R8 entries invalid after reset: everything passes
    send(16'h000D, "R8");
    send(16'h0000, "R2");
    // program table
    cfg_write(N, {2'b00, 16'hFFFF});
    cfg_write(N + 1, 18'h1);
    set_entry(0, 16'h000D, 1, 0);
    set_entry(1, 16'h0011, 1, 1);
    set_entry(2, 16'h0013, 1, 1);
    send(16'h000D, "R4");
    send(16'h0041, "R2");
    send(16'h0011, "R5");
    send(16'h0013, "R6");
    send(16'h0011, "R6");
    // R10 idle
    @(negedge clk);
    check_out("R10", 0, '0, 1'b0);
    // R3 class matching via mask
    cfg_write(N, {2'b00, 16'hFFF0});
    set_entry(3, 16'h0040, 1, 1);
    send(16'h0047, "R3");
    send(16'h0057, "R3");
    // R7 priority: entry 0 eom in same class as entry 3 reject
    set_entry(0, 16'h004F, 1, 0);
    send(16'h0045, "R7");
    // R8 invalidated entry no longer matches
    set_entry(0, 16'h004F, 0, 0);
    send(16'h0045, "R8");
    // R9 clear, enable gating, collision
    cfg_write(N + 1, 18'h3);
    @(negedge clk);
    check_out("R9", 0, '0, 1'b0);
    cfg_write(N + 1, 18'h0);
    send(16'h0042, "R9");
    cfg_write(N + 1, 18'h1);
    @(negedge clk);
    check_out("R9", 0, '0, 1'b0);
    cfg_write(N + 1, 18'h3);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 16'h0044;
    cfg_we = 1'b1; cfg_addr = AW'(N + 1); cfg_wdata = 18'h3;
    @(negedge clk);
    rx_valid = 1'b0; cfg_we = 1'b0;
    m_stat = 1'b1; m_rej = 16'h0044;
    check_out("R9", 2, 16'h0044, 1'b1);
    // random phase
    for (int round = 0; round < 6; round++) begin
      cfg_write(N, {2'b00, 16'($urandom) | 16'($urandom) | 16'hF000});
      for (int i = 0; i < N; i++)
        set_entry(i, 16'($urandom), ($urandom % 4) != 0, $urandom % 2);
      cfg_write(N + 1, 18'($urandom % 4));
      for (int k = 0; k < 60; k++) begin
        if ($urandom % 2) c = m_chr[$urandom % N] ^ (16'($urandom) & ~m_mask);
        else              c = 16'($urandom);
        send(c, "R7");
        if ($urandom % 8 == 0) begin
          @(negedge clk);
          check_out("R10", 0, '0, 1'b0);
        end
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule